// File: doc/BRIEF.md
# Fetch Line Predictor

The fetch line predictor sits beside the instruction cache and picks the line that will be fetched next. The instruction cache is organised as lines of four instructions. The predictor keeps one entry per cache line, and the same fetch line index reads both arrays. Each entry stores three fields: a taken flag, the cache line index the branch goes to, and the word within that line where execution resumes. The lookup is untagged and combinational. In the cycle a line index is presented, the block returns the next line index and start word. That result is either the stored target or, when no taken branch is predicted, the following line starting at word 0.

The branch is resolved three cycles after the prediction. At that point the execution side writes the entry for the branch line through the update port, and the write takes effect at the next clock edge. When an update targets the same line that is being looked up in that cycle, the new values are forwarded straight to the outputs. When the resolved path differs from the prediction, the redirect input supplies the corrected line and word. The redirect has priority over every other source of the next fetch. A reset clears every taken flag, so a freshly reset predictor always fetches sequentially.

Top module: `fetch_line_pred`

## Requirements
- R1: After reset deasserts, every entry reads as not taken, so every lookup gives the sequential result until that entry is written.
- R2: For an entry that is not taken, with no redirect and no forwarded update, next_idx_o is fetch_idx_i plus one modulo 2^IDX_W, so line 1023 is followed by line 0. In the same case next_word_o is 0 and pred_taken_o is 0.
- R3: For a taken entry, with no redirect, next_idx_o and next_word_o equal the stored target line and start word, and pred_taken_o is 1.
- R4: An update writes the taken flag, target line and start word of entry upd_idx_i at the clock edge. It changes no other entry. An update with the taken flag at 0 makes later lookups of that line sequential.
- R5: With redirect_i high, next_idx_o equals redirect_idx_i and next_word_o equals redirect_word_i in the same cycle, and pred_taken_o is 0. This holds whatever the table holds.
- R6: When upd_valid_i is high and upd_idx_i equals fetch_idx_i, with no redirect, the outputs follow the update fields in that same cycle instead of the stored entry.
- R7: An update presented in the same cycle as a redirect is still written to the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; clears all taken flags |
| fetch_idx_i | input | IDX_W | Line index of the current fetch |
| upd_valid_i | input | 1 | Resolved branch update strobe |
| upd_idx_i | input | IDX_W | Line holding the resolved branch |
| upd_taken_i | input | 1 | Resolved taken flag |
| upd_target_i | input | IDX_W | Resolved target line index |
| upd_word_i | input | WORD_W | Resolved start word within the target line |
| redirect_i | input | 1 | Mispredict redirect |
| redirect_idx_i | input | IDX_W | Corrected next line index |
| redirect_word_i | input | WORD_W | Corrected start word |
| next_idx_o | output | IDX_W | Next fetch line index |
| next_word_o | output | WORD_W | Next fetch start word |
| pred_taken_o | output | 1 | Next fetch comes from a predicted taken branch |

## Verification
The assertions check four relations on every cycle. They check the redirect override, the sequential result with word 0 whenever no taken branch is predicted, and same-cycle forwarding of an update. They also check that a line updated in one cycle and looked up in the next returns the written fields. Some behaviours only the bench scenarios can show. These are that reset clears every flag, that a write leaves the other entries untouched, that line 1023 wraps to line 0, and that an update made together with a redirect persists. The bench shows them by comparing against a behavioural table model on every cycle of directed and random traffic.

// File: rtl/flp_pkg.sv
package flp_pkg;
  localparam int unsigned DEF_IDX_W      = 10;
  localparam int unsigned DEF_LINE_WORDS = 4;

  typedef enum logic [1:0] {
    SRC_SEQ = 2'd0,
    SRC_TGT = 2'd1,
    SRC_FIX = 2'd2
  } next_src_e;
endpackage

// File: rtl/flp_taken_bank.sv
module flp_taken_bank #(
  parameter int unsigned IDX_W   = 10,
  localparam int unsigned ENTRIES = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_bit_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_bit_o
);
  logic [ENTRIES-1:0] bits_w;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= 1'b0;
      else if (we_i && (wr_idx_i == IDX_W'(e))) flag_q <= wr_bit_i;
    end
    assign bits_w[e] = flag_q;
  end

  assign rd_bit_o = bits_w[rd_idx_i];
endmodule

// File: rtl/flp_target_ram.sv
module flp_target_ram #(
  parameter int unsigned IDX_W   = 10,
  parameter int unsigned DATA_W  = 12,
  localparam int unsigned ENTRIES = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  // Payload is only consumed when the flag is set, so no reset is needed here.
  logic [DATA_W-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wr_idx_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/flp_next_sel.sv
module flp_next_sel
  import flp_pkg::*;
#(
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned WORD_W = 2
) (
  input  logic [IDX_W-1:0]  fetch_idx_i,
  input  logic              hit_taken_i,
  input  logic [IDX_W-1:0]  hit_target_i,
  input  logic [WORD_W-1:0] hit_word_i,
  input  logic              redirect_i,
  input  logic [IDX_W-1:0]  redirect_idx_i,
  input  logic [WORD_W-1:0] redirect_word_i,
  output logic [IDX_W-1:0]  next_idx_o,
  output logic [WORD_W-1:0] next_word_o,
  output logic              taken_o
);
  next_src_e        src;
  logic [IDX_W-1:0] seq_idx;

  assign seq_idx = fetch_idx_i + IDX_W'(1);  // wraps at the top line

  always_comb begin
    if (redirect_i)       src = SRC_FIX;
    else if (hit_taken_i) src = SRC_TGT;
    else                  src = SRC_SEQ;
  end

  always_comb begin
    unique case (src)
      SRC_FIX: begin
        next_idx_o  = redirect_idx_i;
        next_word_o = redirect_word_i;
      end
      SRC_TGT: begin
        next_idx_o  = hit_target_i;
        next_word_o = hit_word_i;
      end
      default: begin
        next_idx_o  = seq_idx;
        next_word_o = '0;
      end
    endcase
  end

  assign taken_o = (src == SRC_TGT);
endmodule

// File: rtl/fetch_line_pred.sv
module fetch_line_pred
  import flp_pkg::*;
#(
  parameter int unsigned IDX_W      = DEF_IDX_W,
  parameter int unsigned LINE_WORDS = DEF_LINE_WORDS,
  localparam int unsigned WORD_W    = $clog2(LINE_WORDS),
  localparam int unsigned PAY_W     = IDX_W + WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  fetch_idx_i,
  input  logic              upd_valid_i,
  input  logic [IDX_W-1:0]  upd_idx_i,
  input  logic              upd_taken_i,
  input  logic [IDX_W-1:0]  upd_target_i,
  input  logic [WORD_W-1:0] upd_word_i,
  input  logic              redirect_i,
  input  logic [IDX_W-1:0]  redirect_idx_i,
  input  logic [WORD_W-1:0] redirect_word_i,
  output logic [IDX_W-1:0]  next_idx_o,
  output logic [WORD_W-1:0] next_word_o,
  output logic              pred_taken_o
);
  logic             rd_taken;
  logic [PAY_W-1:0] rd_pay;
  logic             fwd;
  logic             hit_taken;
  logic [PAY_W-1:0] hit_pay;

  flp_taken_bank #(.IDX_W(IDX_W)) u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (upd_valid_i),
    .wr_idx_i (upd_idx_i),
    .wr_bit_i (upd_taken_i),
    .rd_idx_i (fetch_idx_i),
    .rd_bit_o (rd_taken)
  );

  flp_target_ram #(.IDX_W(IDX_W), .DATA_W(PAY_W)) u_targets (
    .clk_i     (clk_i),
    .we_i      (upd_valid_i),
    .wr_idx_i  (upd_idx_i),
    .wr_data_i ({upd_target_i, upd_word_i}),
    .rd_idx_i  (fetch_idx_i),
    .rd_data_o (rd_pay)
  );

  // Same-line update bypasses the array read.
  assign fwd       = upd_valid_i && (upd_idx_i == fetch_idx_i);
  assign hit_taken = fwd ? upd_taken_i : rd_taken;
  assign hit_pay   = fwd ? {upd_target_i, upd_word_i} : rd_pay;

  flp_next_sel #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_sel (
    .fetch_idx_i     (fetch_idx_i),
    .hit_taken_i     (hit_taken),
    .hit_target_i    (hit_pay[PAY_W-1:WORD_W]),
    .hit_word_i      (hit_pay[WORD_W-1:0]),
    .redirect_i      (redirect_i),
    .redirect_idx_i  (redirect_idx_i),
    .redirect_word_i (redirect_word_i),
    .next_idx_o      (next_idx_o),
    .next_word_o     (next_word_o),
    .taken_o         (pred_taken_o)
  );
endmodule

// File: rtl/flp_checks.sv
module flp_checks #(
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned WORD_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [IDX_W-1:0]  fetch_idx_i,
  input logic              upd_valid_i,
  input logic [IDX_W-1:0]  upd_idx_i,
  input logic              upd_taken_i,
  input logic [IDX_W-1:0]  upd_target_i,
  input logic [WORD_W-1:0] upd_word_i,
  input logic              redirect_i,
  input logic [IDX_W-1:0]  redirect_idx_i,
  input logic [WORD_W-1:0] redirect_word_i,
  input logic [IDX_W-1:0]  next_idx_o,
  input logic [WORD_W-1:0] next_word_o,
  input logic              pred_taken_o
);
  logic [IDX_W-1:0] seq_exp;
  logic             same_line_upd;
  assign seq_exp       = fetch_idx_i + IDX_W'(1);
  assign same_line_upd = upd_valid_i && (upd_idx_i == fetch_idx_i);

  a_r5_redirect_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |-> (next_idx_o == redirect_idx_i) && (next_word_o == redirect_word_i)
                   && !pred_taken_o);

  a_r2_seq_word0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!redirect_i && !pred_taken_o) |-> (next_idx_o == seq_exp) && (next_word_o == '0));

  a_r6_forward: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (same_line_upd && !redirect_i) |->
      (pred_taken_o == upd_taken_i) &&
      (!upd_taken_i || ((next_idx_o == upd_target_i) && (next_word_o == upd_word_i))));

  a_r4_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(upd_valid_i) && (fetch_idx_i == $past(upd_idx_i))
     && !same_line_upd && !redirect_i) |->
      (pred_taken_o == $past(upd_taken_i)) &&
      (!$past(upd_taken_i) ||
       ((next_idx_o == $past(upd_target_i)) && (next_word_o == $past(upd_word_i)))));
endmodule

bind fetch_line_pred flp_checks #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_flp_checks (.*);

// File: tb/fetch_line_pred_bench.sv
`timescale 1ns/1ps
module fetch_line_pred_bench;
  localparam int IW = 10;
  localparam int WW = 2;
  localparam int N  = 1 << IW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [IW-1:0] fetch_idx = '0;
  logic          upd_valid = 1'b0;
  logic [IW-1:0] upd_idx = '0;
  logic          upd_taken = 1'b0;
  logic [IW-1:0] upd_target = '0;
  logic [WW-1:0] upd_word = '0;
  logic          redirect = 1'b0;
  logic [IW-1:0] redirect_idx = '0;
  logic [WW-1:0] redirect_word = '0;
  logic [IW-1:0] next_idx;
  logic [WW-1:0] next_word;
  logic          pred_taken;

  int tests = 0;
  int fails = 0;

  bit model_taken [N];
  int model_tgt   [N];
  int model_word  [N];

  always #4 clk = ~clk;

  fetch_line_pred u_fetch_line_pred (
    .clk_i(clk), .rst_ni(rst_ni), .fetch_idx_i(fetch_idx),
    .upd_valid_i(upd_valid), .upd_idx_i(upd_idx), .upd_taken_i(upd_taken),
    .upd_target_i(upd_target), .upd_word_i(upd_word),
    .redirect_i(redirect), .redirect_idx_i(redirect_idx), .redirect_word_i(redirect_word),
    .next_idx_o(next_idx), .next_word_o(next_word), .pred_taken_o(pred_taken)
  );

  task automatic clear_model();
    for (int i = 0; i < N; i++) model_taken[i] = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    upd_valid = 1'b0;
    redirect = 1'b0;
    clear_model();
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic step(input int f, input bit uv, input int ui, input bit ut, input int utg,
                      input int uw, input bit rd, input int ri, input int rw, input string tag);
    int ei, ew;
    bit et;
    @(negedge clk);
    fetch_idx = IW'(f); upd_valid = uv; upd_idx = IW'(ui); upd_taken = ut;
    upd_target = IW'(utg); upd_word = WW'(uw);
    redirect = rd; redirect_idx = IW'(ri); redirect_word = WW'(rw);
    #1;
    if (rd) begin
      ei = ri; ew = rw; et = 1'b0;
    end else if (uv && ui == f) begin
      et = ut; ei = ut ? utg : (f + 1) % N; ew = ut ? uw : 0;
    end else if (model_taken[f]) begin
      et = 1'b1; ei = model_tgt[f]; ew = model_word[f];
    end else begin
      et = 1'b0; ei = (f + 1) % N; ew = 0;
    end
    tests++;
    if (int'(next_idx) != ei || int'(next_word) != ew || pred_taken != et) begin
      fails++;
      $display("FAIL %s fetch=%0d: got idx=%0d word=%0d taken=%0b, exp idx=%0d word=%0d taken=%0b",
               tag, f, next_idx, next_word, pred_taken, ei, ew, et);
    end
    @(posedge clk);
    if (uv) begin
      model_taken[ui] = ut; model_tgt[ui] = utg; model_word[ui] = uw;
    end
  endtask

  task automatic look(input int f, input string tag);
    step(f, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    clear_model();
    do_reset();
    // R1 and R2: fresh table is sequential; top line wraps
    look(0, "R1 reset");
    look(5, "R1 reset");
    look(511, "R1 reset");
    look(1023, "R2 wrap");
    // R4: write line 5, lookup elsewhere untouched
    step(7, 1, 5, 1, 300, 2, 0, 0, 0, "R2 seq during update");
    look(5, "R3 taken target");
    look(6, "R4 neighbour untouched");
    look(4, "R4 neighbour untouched");
    // R6: same-line update forwards, then persists
    step(9, 1, 9, 1, 17, 3, 0, 0, 0, "R6 forward");
    look(9, "R3 after forward");
    step(9, 1, 9, 0, 44, 1, 0, 0, 0, "R6 forward not taken");
    look(9, "R4 cleared");
    // taken target at top line
    step(1023, 1, 1023, 1, 1023, 3, 0, 0, 0, "R6 forward top line");
    look(1023, "R3 top line");
    // R5 and R7: redirect beats a taken entry and an update still lands
    step(5, 1, 12, 1, 88, 1, 1, 200, 3, "R5 redirect over taken, R7 update");
    look(12, "R7 update during redirect");
    step(12, 1, 12, 1, 99, 2, 1, 3, 0, "R5 redirect over forward");
    look(12, "R7 second write kept");
    // R4: clear line 5
    step(0, 1, 5, 0, 0, 0, 0, 0, 0, "R2 seq");
    look(5, "R4 clear taken");
    // random traffic on a small window of lines
    for (int n = 0; n < 400; n++) begin
      int f, ui;
      f  = ($urandom_range(0, 9) == 0) ? 1023 : int'($urandom_range(0, 15));
      ui = ($urandom_range(0, 3) == 0) ? f : int'($urandom_range(0, 15));
      step(f, $urandom_range(0, 2) == 0, ui, $urandom_range(0, 1) == 1,
           int'($urandom_range(0, N - 1)), int'($urandom_range(0, 3)),
           $urandom_range(0, 7) == 0, int'($urandom_range(0, N - 1)),
           int'($urandom_range(0, 3)), "R3 R4 R6 random");
    end
    // R1: mid-run reset clears written lines
    step(3, 1, 3, 1, 50, 1, 0, 0, 0, "R6 forward");
    do_reset();
    look(3, "R1 after reset");
    look(12, "R1 after reset");
    look(1023, "R1 after reset");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule